// File: doc/BRIEF.md
# Remote DMA Engine

This block moves data between a host data port and the controller's local buffer memory. Software first programs a 16-bit start address, a 16-bit byte count and a small configuration register. It then writes an operation code into the command register. From then on, each host access to the data port moves one byte or one 16-bit word between the port and memory. The current address rises by the number of bytes moved and the remaining count falls by the same amount. When the count reaches zero the engine goes idle and pulses a completion event for the interrupt unit.

An abort code stops a transfer at once and leaves the current address where the transfer stopped. The current address can be read back at the two register offsets that take the start address. The send-packet code is decoded and reported, and it moves data in the read direction. Memory is modelled as two byte lanes with combinational read: lane 0 holds the byte at `mem_addr` and lane 1 holds the byte at `mem_addr + 1`.

Register offsets on `reg_addr`:

| Offset | Register | Contents |
|---|---|---|
| 0 | command | operation code in bits [2:0] |
| 1 | start address, low byte | readback returns the current address low byte |
| 2 | start address, high byte | readback returns the current address high byte |
| 3 | byte count, low byte | |
| 4 | byte count, high byte | |
| 5 | configuration | bit 0 selects word mode, bit 1 selects byte order |

Top module: `rdma_engine`

## Requirements
- R1: After reset the engine is idle. `xfer_busy`, `xfer_done`, `xfer_kind`, `mem_we` and `dp_rdata` are all 0, and the address readback is 0.
- R2: A command write to offset 0 with bits [2:0] = 001 starts a read, 010 starts a write and 011 starts a send packet. `xfer_kind` then reports 1, 2 or 3 while busy. Each start copies the start address and byte count into the current address and remaining count.
- R3: A command write with bits [2:0] = 000 changes nothing, whether the engine is idle or busy. This includes `xfer_busy`, `xfer_kind` and the current address.
- R4: A command write with bit 2 set is an abort, whatever bits [1:0] hold. It clears `xfer_busy` at the next edge and raises no `xfer_done`. The current address stays where the transfer stopped.
- R5: In byte mode (configuration bit 0 = 0), each accepted access moves one byte. A read returns that byte on `dp_rdata[7:0]` with the upper byte 0. The address rises by 1 and the count falls by 1.
- R6: In word mode (configuration bit 0 = 1), each accepted access moves two bytes and the address and count change by 2. When exactly one byte remains, the access moves only that byte and the change is 1.
- R7: Configuration bit 1 = 0 puts the byte at the lower address in the low half of the host word. Bit 1 = 1 puts it in the high half. On a final single byte of a word-mode access, the unused half reads 0.
- R8: `xfer_done` is high for exactly the one cycle after the edge at which the remaining count reaches zero, and `xfer_busy` is low in that cycle. A start with a zero byte count raises `xfer_done` after the command edge and moves no data.
- R9: Offsets 1 and 2 read back the current address. While the engine is idle, writing either start-address byte also sets the current address.
- R10: While idle, and for a data-port access in the direction opposite to the active operation, `dp_rdata` is 0 and `mem_we` is 0. Neither the address nor the count changes.
- R11: In a write operation, an accepted access drives `mem_we` = 11 for two bytes and 01 for one byte, never 10. The lane data follows the byte order of R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for writes and readback |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Readback; current address bytes at offsets 1 and 2, else 0 |
| dp_rd | input | 1 | Host data-port read strobe |
| dp_wr | input | 1 | Host data-port write strobe |
| dp_wdata | input | 16 | Host data-port write data |
| dp_rdata | output | 16 | Host data-port read data |
| mem_addr | output | 16 | Current local memory address (lane 0 byte) |
| mem_rdata | input | 16 | Memory read data, lane 0 low, lane 1 high |
| mem_wdata | output | 16 | Memory write data, lane 0 low, lane 1 high |
| mem_we | output | 2 | Per-lane write enables |
| xfer_busy | output | 1 | A transfer is active |
| xfer_kind | output | 2 | Active operation: 0 none, 1 read, 2 write, 3 send packet |
| xfer_done | output | 1 | One-cycle completion event |

## Verification
The checks assume the host never issues a start or abort command in the same cycle as a data-port access. They also assume no command is written in the cycle right after completion, and that the start address is not rewritten during a memory write. The bench keeps to this by using tasks that each drive only one kind of access per clock, with every strobe raised at a falling edge and dropped after one rising edge. The read vectors cover byte mode, both word byte orders, an odd final byte and address wrap past 0xFFFF. Directed cases then cover abort, the ignored code, a zero count, wrong-direction accesses and the write lanes.

// File: rtl/rdma_pkg.sv
// Shared types and register offsets for the remote DMA engine.
// Assumes a 3-bit register offset space and 8-bit register data.
package rdma_pkg;
    localparam logic [2:0] OFF_CMD   = 3'd0;
    localparam logic [2:0] OFF_SA_LO = 3'd1;
    localparam logic [2:0] OFF_SA_HI = 3'd2;
    localparam logic [2:0] OFF_BC_LO = 3'd3;
    localparam logic [2:0] OFF_BC_HI = 3'd4;
    localparam logic [2:0] OFF_CFG   = 3'd5;

    localparam int CFG_WORD_BIT = 0;
    localparam int CFG_BOS_BIT  = 1;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_SEND  = 2'd3
    } op_e;
endpackage

// File: rtl/rdma_cmd_decode.sv
// Decodes the 3-bit operation code of the command register.
// Assumes the code is only meaningful in a cycle where the command register is written.
module rdma_cmd_decode
    import rdma_pkg::*;
(
    input  logic [2:0] code,
    output op_e        op,
    output logic       is_start,
    output logic       is_abort
);
    // Top bit overrides the others; a zero low pair is the unused code.
    always_comb begin
        is_abort = code[2];
        is_start = !code[2] && (code[1:0] != 2'b00);
        op       = op_e'(code[1:0]);
    end
endmodule

// File: rtl/rdma_lane_map.sv
// Maps memory byte lanes to and from the host data word.
// Assumes lane 0 is the byte at the current address, lane 1 the next one.
module rdma_lane_map (
    input  logic        word_mode,
    input  logic        big_first,
    input  logic        two_bytes,
    input  logic [15:0] mem_rdata,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    output logic [15:0] mem_wdata
);
    logic [7:0] second;

    // Select byte placement from transfer width and byte order.
    always_comb begin
        second = two_bytes ? mem_rdata[15:8] : 8'h00;
        if (!word_mode) begin
            host_rdata = {8'h00, mem_rdata[7:0]};
            mem_wdata  = {8'h00, host_wdata[7:0]};
        end else if (!big_first) begin
            host_rdata = {second, mem_rdata[7:0]};
            mem_wdata  = host_wdata;
        end else begin
            host_rdata = {mem_rdata[7:0], second};
            mem_wdata  = {host_wdata[7:0], host_wdata[15:8]};
        end
    end
endmodule

// File: rtl/rdma_addr_count.sv
// Holds the current address, remaining count, busy flag and done pulse.
// Assumes advance is only raised while busy; priority is abort, load, advance, set.
module rdma_addr_count #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [CNT_W-1:0]  load_cnt,
    input  logic              advance,
    input  logic              step_two,
    input  logic              set_addr,
    input  logic [ADDR_W-1:0] set_val,
    output logic [ADDR_W-1:0] addr_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              busy_q,
    output logic              done_q
);
    logic [CNT_W-1:0]  cnt_step;
    logic [ADDR_W-1:0] addr_step;

    // Step size of one accepted access.
    always_comb begin
        cnt_step  = step_two ? CNT_W'(2) : CNT_W'(1);
        addr_step = step_two ? ADDR_W'(2) : ADDR_W'(1);
    end

    // Transfer state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (abort) begin
                busy_q <= 1'b0;
            end else if (load) begin
                addr_q <= load_addr;
                cnt_q  <= load_cnt;
                busy_q <= (load_cnt != '0);
                done_q <= (load_cnt == '0);
            end else if (advance) begin
                addr_q <= addr_q + addr_step;
                cnt_q  <= cnt_q - cnt_step;
                if (cnt_q == cnt_step) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end else if (set_addr) begin
                addr_q <= set_val;
            end
        end
    end
endmodule

// File: rtl/rdma_engine.sv
// Remote DMA engine: register file, command handling and host data port.
// Assumes memory with combinational read and byte-lane writes on the clock edge.
module rdma_engine
    import rdma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              dp_rd,
    input  logic              dp_wr,
    input  logic [15:0]       dp_wdata,
    output logic [15:0]       dp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [15:0]       mem_rdata,
    output logic [15:0]       mem_wdata,
    output logic [1:0]        mem_we,
    output logic              xfer_busy,
    output logic [1:0]        xfer_kind,
    output logic              xfer_done
);
    localparam int BYTE_W = 8;

    logic [ADDR_W-1:0] start_q, start_d;
    logic [CNT_W-1:0]  count_q;
    logic              word_q, bos_q;
    op_e               op_q, dec_op;
    logic              dec_start, dec_abort;
    logic              cmd_wr, do_start, do_abort;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              busy_q, done_q;
    logic              rd_dir, wr_dir, acc_rd, acc_wr, two_bytes, set_addr;
    logic [15:0]       lane_rdata;

    rdma_cmd_decode u_dec (
        .code     (reg_wdata[2:0]),
        .op       (dec_op),
        .is_start (dec_start),
        .is_abort (dec_abort)
    );

    // Command strobes from a write to the command offset.
    always_comb begin
        cmd_wr   = reg_we && (reg_addr == OFF_CMD);
        do_start = cmd_wr && dec_start;
        do_abort = cmd_wr && dec_abort;
    end

    // Merge a start-address byte write into the held value.
    always_comb begin
        start_d = start_q;
        if (reg_we && reg_addr == OFF_SA_LO) start_d[BYTE_W-1:0] = reg_wdata;
        if (reg_we && reg_addr == OFF_SA_HI) start_d[ADDR_W-1:BYTE_W] = reg_wdata;
        set_addr = !busy_q && reg_we && (reg_addr == OFF_SA_LO || reg_addr == OFF_SA_HI);
    end

    // Programmable registers and the latched operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            count_q <= '0;
            word_q  <= 1'b0;
            bos_q   <= 1'b0;
            op_q    <= OP_NONE;
        end else begin
            start_q <= start_d;
            if (reg_we && reg_addr == OFF_BC_LO) count_q[BYTE_W-1:0] <= reg_wdata;
            if (reg_we && reg_addr == OFF_BC_HI) count_q[CNT_W-1:BYTE_W] <= reg_wdata;
            if (reg_we && reg_addr == OFF_CFG) begin
                word_q <= reg_wdata[CFG_WORD_BIT];
                bos_q  <= reg_wdata[CFG_BOS_BIT];
            end
            if (do_start) op_q <= dec_op;
        end
    end

    // Accepted accesses: only in the direction of the active operation.
    always_comb begin
        rd_dir    = (op_q == OP_READ) || (op_q == OP_SEND);
        wr_dir    = (op_q == OP_WRITE);
        acc_rd    = busy_q && dp_rd && rd_dir;
        acc_wr    = busy_q && dp_wr && wr_dir;
        two_bytes = word_q && (cnt_q > CNT_W'(1));
    end

    rdma_addr_count #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort     (do_abort),
        .load      (do_start),
        .load_addr (start_q),
        .load_cnt  (count_q),
        .advance   (acc_rd || acc_wr),
        .step_two  (two_bytes),
        .set_addr  (set_addr),
        .set_val   (start_d),
        .addr_q    (addr_q),
        .cnt_q     (cnt_q),
        .busy_q    (busy_q),
        .done_q    (done_q)
    );

    rdma_lane_map u_lane (
        .word_mode  (word_q),
        .big_first  (bos_q),
        .two_bytes  (two_bytes),
        .mem_rdata  (mem_rdata),
        .host_wdata (dp_wdata),
        .host_rdata (lane_rdata),
        .mem_wdata  (mem_wdata)
    );

    // Port outputs and address readback.
    always_comb begin
        dp_rdata  = acc_rd ? lane_rdata : 16'h0000;
        mem_we    = acc_wr ? {two_bytes, 1'b1} : 2'b00;
        mem_addr  = addr_q;
        xfer_busy = busy_q;
        xfer_done = done_q;
        xfer_kind = busy_q ? op_q : OP_NONE;
        case (reg_addr)
            OFF_SA_LO: reg_rdata = addr_q[BYTE_W-1:0];
            OFF_SA_HI: reg_rdata = addr_q[ADDR_W-1:BYTE_W];
            default:   reg_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/rdma_engine_chk.sv
// Property checker for the remote DMA engine, bound to the top module.
// Assumes no command is issued in the same cycle as a data-port access.
module rdma_engine_chk
    import rdma_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        reg_we,
    input logic [2:0]  reg_addr,
    input logic [2:0]  cmd_code,
    input logic        dp_rd,
    input logic        dp_wr,
    input logic [15:0] dp_rdata,
    input logic [1:0]  mem_we,
    input logic [15:0] mem_addr,
    input logic        xfer_busy,
    input logic        xfer_done
);
    // Idle engine drives no data and no writes.
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_busy |-> (dp_rdata == 16'h0000 && mem_we == 2'b00));

    // Idle engine without register writes holds its address.
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_busy && !reg_we) |=> $stable(mem_addr));

    // Abort ends the transfer without a completion event.
    p_abort_stops_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == OFF_CMD && cmd_code[2]) |=> (!xfer_busy && !xfer_done));

    // Unused code leaves busy unchanged and raises nothing.
    p_reserved_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == OFF_CMD && cmd_code == 3'b000 && !dp_rd && !dp_wr)
        |=> ($stable(xfer_busy) && !xfer_done));

    // Completion coincides with the end of busy.
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> !xfer_busy);

    // A memory write advances the address by the number of lanes written.
    p_write_advance_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we != 2'b00 && !reg_we)
        |=> (mem_addr == $past(mem_addr) + 16'($countones($past(mem_we)))));

    // Lane 1 is never written alone.
    p_lane_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we != 2'b10);
endmodule

bind rdma_engine rdma_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .cmd_code  (reg_wdata[2:0]),
    .dp_rd     (dp_rd),
    .dp_wr     (dp_wr),
    .dp_rdata  (dp_rdata),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .xfer_busy (xfer_busy),
    .xfer_done (xfer_done)
);

// File: tb/rdma_engine_tb_top.sv
module rdma_engine_tb_top;
    localparam int CLK_PERIOD = 10;

    localparam logic [2:0] A_CMD = 3'd0, A_SLO = 3'd1, A_SHI = 3'd2,
                           A_CLO = 3'd3, A_CHI = 3'd4, A_CFG = 3'd5;

    // {word, bos, start, count}
    localparam logic [33:0] VEC [4] = '{
        {1'b0, 1'b0, 16'h0010, 16'd3},
        {1'b1, 1'b0, 16'h0020, 16'd4},
        {1'b1, 1'b1, 16'h0030, 16'd5},
        {1'b0, 1'b0, 16'hFFFE, 16'd3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        dp_rd = 1'b0, dp_wr = 1'b0;
    logic [15:0] dp_wdata = 16'h0000;
    logic [15:0] dp_rdata, mem_addr, mem_rdata, mem_wdata;
    logic [1:0]  mem_we, xfer_kind;
    logic        xfer_busy, xfer_done;

    logic [7:0]  bmem [256];
    int          checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mem_rdata = {bmem[mem_addr[7:0] + 8'd1], bmem[mem_addr[7:0]]};

    always @(posedge clk) begin
        if (mem_we[0]) bmem[mem_addr[7:0]] <= mem_wdata[7:0];
        if (mem_we[1]) bmem[mem_addr[7:0] + 8'd1] <= mem_wdata[15:8];
    end

    rdma_engine dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dp_rd(dp_rd),
        .dp_wr(dp_wr), .dp_wdata(dp_wdata), .dp_rdata(dp_rdata),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .xfer_busy(xfer_busy), .xfer_kind(xfer_kind),
        .xfer_done(xfer_done)
    );

    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ 8'h5A;
    endfunction

    function automatic logic [15:0] exp_rd(input logic [15:0] a, input logic w,
                                           input logic b, input logic two);
        logic [7:0] b0, b1;
        b0 = pat(a);
        b1 = two ? pat(a + 16'd1) : 8'h00;
        if (!w) return {8'h00, b0};
        return b ? {b0, b1} : {b1, b0};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Entered and left at a falling edge.
    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic host_read(output logic [15:0] d, output logic dn);
        dp_rd = 1'b1; #1; d = dp_rdata;
        @(posedge clk); @(negedge clk);
        dp_rd = 1'b0; dn = xfer_done;
    endtask

    task automatic host_write(input logic [15:0] d, output logic [1:0] we, output logic dn);
        dp_wr = 1'b1; dp_wdata = d; #1; we = mem_we;
        @(posedge clk); @(negedge clk);
        dp_wr = 1'b0; dn = xfer_done;
    endtask

    task automatic setup(input logic w, input logic b, input logic [15:0] sa, input logic [15:0] n);
        wr_reg(A_CFG, {6'd0, b, w});
        wr_reg(A_SLO, sa[7:0]);
        wr_reg(A_SHI, sa[15:8]);
        wr_reg(A_CLO, n[7:0]);
        wr_reg(A_CHI, n[15:8]);
    endtask

    logic [15:0] d16, a16, rem;
    logic [7:0]  lo, hi;
    logic [1:0]  we;
    logic        dn, two;

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) bmem[i] = 8'(i) ^ 8'h5A;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 busy", xfer_busy, 0);
        check("R1 done", xfer_done, 0);
        check("R1 kind", xfer_kind, 0);
        check("R1 mem_we", mem_we, 0);
        rd_reg(A_SLO, lo);
        check("R1 addr readback", lo, 0);

        // Table of read transfers
        for (int v = 0; v < 4; v++) begin
            setup(VEC[v][33], VEC[v][32], VEC[v][31:16], VEC[v][15:0]);
            wr_reg(A_CMD, (v == 3) ? 8'h03 : 8'h01);
            check("R2 kind after start", xfer_kind, (v == 3) ? 3 : 1);
            check("R2 busy after start", xfer_busy, 1);
            a16 = VEC[v][31:16];
            rem = VEC[v][15:0];
            while (rem != 0) begin
                two = VEC[v][33] && (rem > 1);
                host_read(d16, dn);
                if (VEC[v][33]) check("R6 R7 word data", d16, exp_rd(a16, 1'b1, VEC[v][32], two));
                else            check("R5 byte data", d16, exp_rd(a16, 1'b0, 1'b0, 1'b0));
                a16 = a16 + (two ? 16'd2 : 16'd1);
                rem = rem - (two ? 16'd2 : 16'd1);
                check("R8 done timing", dn, rem == 0);
            end
            rd_reg(A_SLO, lo);
            rd_reg(A_SHI, hi);
            check("R9 final address", {hi, lo}, a16);
            check("R8 busy after done", xfer_busy, 0);
        end

        // R9 idle start-address write sets readback
        wr_reg(A_SLO, 8'h34);
        wr_reg(A_SHI, 8'h12);
        rd_reg(A_SLO, lo);
        rd_reg(A_SHI, hi);
        check("R9 idle readback", {hi, lo}, 16'h1234);

        // R10 idle access has no effect
        host_read(d16, dn);
        check("R10 idle read data", d16, 0);
        host_write(16'hFFFF, we, dn);
        check("R10 idle mem_we", we, 0);
        rd_reg(A_SLO, lo);
        check("R10 idle address kept", lo, 8'h34);

        // R3 unused code while idle and while busy
        wr_reg(A_CMD, 8'h00);
        check("R3 idle busy", xfer_busy, 0);
        setup(1'b0, 1'b0, 16'h0050, 16'd6);
        wr_reg(A_CMD, 8'h01);
        host_read(d16, dn);
        wr_reg(A_CMD, 8'h00);
        check("R3 busy kept", xfer_busy, 1);
        check("R3 kind kept", xfer_kind, 1);
        rd_reg(A_SLO, lo);
        check("R3 address kept", lo, 8'h51);

        // R10 wrong-direction write during a read
        host_write(16'hBEEF, we, dn);
        check("R10 wrong dir mem_we", we, 0);
        rd_reg(A_SLO, lo);
        check("R10 wrong dir address", lo, 8'h51);
        host_read(d16, dn);
        check("R5 continue after ignored", d16, {8'h00, pat(16'h0051)});

        // R4 abort with nonzero low bits
        wr_reg(A_CMD, 8'h05);
        check("R4 busy cleared", xfer_busy, 0);
        check("R4 no done", xfer_done, 0);
        rd_reg(A_SLO, lo);
        check("R4 address kept", lo, 8'h52);
        host_read(d16, dn);
        check("R4 read after abort", d16, 0);

        // R11 word write, big-first order, odd tail
        setup(1'b1, 1'b1, 16'h0040, 16'd3);
        wr_reg(A_CMD, 8'h02);
        check("R2 write kind", xfer_kind, 2);
        host_write(16'hA1B2, we, dn);
        check("R11 two-lane enable", we, 2'b11);
        host_write(16'hC3D4, we, dn);
        check("R11 single-lane enable", we, 2'b01);
        check("R8 write done", dn, 1);
        check("R11 byte 40", bmem[8'h40], 8'hA1);
        check("R11 byte 41", bmem[8'h41], 8'hB2);
        check("R11 byte 42", bmem[8'h42], 8'hC3);
        check("R11 byte 43 untouched", bmem[8'h43], pat(16'h0043));

        // R11 byte-mode write
        setup(1'b0, 1'b0, 16'h0048, 16'd1);
        wr_reg(A_CMD, 8'h02);
        host_write(16'h5577, we, dn);
        check("R11 byte lane", we, 2'b01);
        check("R11 byte value", bmem[8'h48], 8'h77);
        check("R11 next untouched", bmem[8'h49], pat(16'h0049));

        // R8 zero count start
        setup(1'b0, 1'b0, 16'h0060, 16'd0);
        wr_reg(A_CMD, 8'h01);
        check("R8 zero count done", xfer_done, 1);
        check("R8 zero count idle", xfer_busy, 0);
        @(negedge clk);
        check("R8 done single cycle", xfer_done, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule